// File: doc/BRIEF.md
# Programmable Bus Waveform Sequencer

This block generates the strobe waveforms of an external asynchronous bus from microcode. A store of 64 pattern words, each 32 bits wide, describes the strobes clock by clock. Each word gives the chip-select, write-enable and output-enable levels for the four quarter phases of one clock. It can also hold itself for several clocks, mark the edges of a loop body, stall on an external ready input, pulse the transfer acknowledge, or end the pattern. A bus access request starts the read pattern or the write pattern at a fixed entry word. The sequencer then walks the store until a word with the end bit has run.

A host port writes a mode register and a data register. The mode field chooses what an access request does. In normal mode a request runs a pattern. In store-write mode it deposits the data register into the store. In store-read mode it copies a store word into the data register. In run mode it runs a pattern from the address field. The two store modes then advance the address field, so the host can fill or dump the store with a stream of dummy accesses. The strobe outputs are active low. Each output is a 4-bit vector whose bit 3 is the first quarter of the clock and whose bit 0 is the last.

Top module: `wavefmt_seq`

## Requirements
- R1: After reset and whenever the sequencer is idle (`busy` low), `cs_n`, `we_n` and `oe_n` are 4'hF and `xfer_ack` is 0. After reset, the mode register reads back as 0.
- R2: In normal mode (mode field 0), an access request accepted while idle starts the pattern on the next clock. The first word shown is word 0 when `acc_write` is 0 and word 24 when `acc_write` is 1.
- R3: While a word executes, `cs_n` equals word bits 31:28 and `we_n` equals word bits 27:24, bit 3 of each output taking the highest word bit. `oe_n` equals {b17,b17,b16,b16}.
- R4: Word bits 9:8 hold a repeat value n. A word lasts n+1 clocks when it does not stall.
- R5: When word bit 12 is set and `bus_rdy` is low, the word stays on the outputs and its repeat progress is frozen. It continues once `bus_rdy` is high.
- R6: `xfer_ack` is high on each non-stalled clock of a word with bit 2 set, and is high at no other time.
- R7: A word with bit 0 set ends the pattern. `busy` drops and all strobes are negated on the clock after that word's last clock.
- R8: In store-write mode (mode 1), an access request writes the data register into the word at the address field, and the address field then increments by one.
- R9: In store-read mode (mode 2), an access request loads the word at the address field into the data register, and the address field then increments by one.
- R10: Bit 7 marks the first and the last word of a loop body. The body runs N times, where N is the loop count of the access: bits 23:20 of the mode register for reads, bits 19:16 for writes. A count of 0 runs the body once.
- R11: In run mode (mode 3), an access request starts the pattern at the address field and uses the read loop count, whatever the value of `acc_write`.
- R12: An access request made while `busy` is high has no effect on the running pattern. A request in a store mode does not start a pattern.
- R13: After reset, every store word holds the idle word 32'hFFF30001: all strobes negated, end bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 mode register, 1 data register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read-back of the selected register |
| acc_req | input | 1 | Access request pulse |
| acc_write | input | 1 | Access direction: 1 write, 0 read |
| bus_rdy | input | 1 | External ready, high when the device can proceed |
| cs_n | output | 4 | Chip-select level per quarter phase, active low |
| we_n | output | 4 | Write-enable level per quarter phase, active low |
| oe_n | output | 4 | Output-enable level per quarter phase, active low |
| xfer_ack | output | 1 | Transfer acknowledge |
| busy | output | 1 | A pattern is executing |

## Verification
The bench builds the block with its default parameters: a 64-word store, 4-bit loop counts, and entries at words 0 and 24. With these values the host can place both patterns with dummy accesses and read back the store at an address no pattern touches, where the reset idle word must still sit. The read pattern covers the three-clock repeat, a stall that lasts three clocks, a split output-enable and the acknowledge, and it also receives a request while it is busy. The write pattern at the second entry runs its loop body with counts of 3 and 0, and run mode starts the same body from the address field with count 2 and also runs a lone idle word.

// File: rtl/wavefmt_pkg.sv
package wavefmt_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_WRAM   = 2'd1,
    MODE_RRAM   = 2'd2,
    MODE_RUN    = 2'd3
  } seq_mode_e;

  localparam int WORD_W   = 32;
  localparam int B_CS_HI  = 31;
  localparam int B_WE_HI  = 27;
  localparam int B_OE_A   = 17;
  localparam int B_OE_B   = 16;
  localparam int B_WAIT   = 12;
  localparam int B_REP_HI = 9;
  localparam int B_REP_LO = 8;
  localparam int B_LOOP   = 7;
  localparam int B_ACK    = 2;
  localparam int B_LAST   = 0;
  localparam int REP_W    = B_REP_HI - B_REP_LO + 1;

  // mode register field positions
  localparam int MF_MODE_LSB = 28;
  localparam int MF_RDC_LSB  = 20;
  localparam int MF_WRC_LSB  = 16;

  localparam logic [WORD_W-1:0] IDLE_WORD = 32'hFFF3_0001;

endpackage

// File: rtl/wavefmt_ram.sv
module wavefmt_ram
  import wavefmt_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_exec,
  input  logic [ADDR_W-1:0] raddr_host,
  output logic [WORD_W-1:0] rdata_exec,
  output logic [WORD_W-1:0] rdata_host
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= IDLE_WORD;
    end else if (wr_en) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata_exec = mem_q[raddr_exec];
  assign rdata_host = mem_q[raddr_host];

endmodule

// File: rtl/wavefmt_regs.sv
module wavefmt_regs
  import wavefmt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              addr_inc,
  input  logic              data_load,
  input  logic [WORD_W-1:0] data_in,
  output seq_mode_e         mode,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic [CNT_W-1:0]  wr_cnt,
  output logic [WORD_W-1:0] mode_word,
  output logic [WORD_W-1:0] data_word
);

  seq_mode_e         mode_q, mode_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rdc_q, rdc_d, wrc_q, wrc_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              mode_en, data_en;

  assign mode_en = host_wr & ~host_sel;
  assign data_en = (host_wr & host_sel) | data_load;

  always_comb begin
    mode_d = mode_q;
    addr_d = addr_q;
    rdc_d  = rdc_q;
    wrc_d  = wrc_q;
    if (mode_en) begin
      mode_d = seq_mode_e'(host_wdata[MF_MODE_LSB +: 2]);
      addr_d = host_wdata[ADDR_W-1:0];
      rdc_d  = host_wdata[MF_RDC_LSB +: CNT_W];
      wrc_d  = host_wdata[MF_WRC_LSB +: CNT_W];
    end else if (addr_inc) begin
      addr_d = addr_q + 1'b1;
    end
    data_d = (host_wr & host_sel) ? host_wdata : data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      addr_q <= '0;
      rdc_q  <= '0;
      wrc_q  <= '0;
    end else if (mode_en | addr_inc) begin
      mode_q <= mode_d;
      addr_q <= addr_d;
      rdc_q  <= rdc_d;
      wrc_q  <= wrc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_comb begin
    mode_word = '0;
    mode_word[MF_MODE_LSB +: 2]    = mode_q;
    mode_word[MF_RDC_LSB +: CNT_W] = rdc_q;
    mode_word[MF_WRC_LSB +: CNT_W] = wrc_q;
    mode_word[ADDR_W-1:0]          = addr_q;
  end

  assign mode      = mode_q;
  assign addr      = addr_q;
  assign rd_cnt    = rdc_q;
  assign wr_cnt    = wrc_q;
  assign data_word = data_q;

endmodule

// File: rtl/wavefmt_engine.sv
module wavefmt_engine
  import wavefmt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic [CNT_W-1:0]  start_cnt,
  input  logic [WORD_W-1:0] word,
  input  logic              rdy,
  output logic              busy,
  output logic [ADDR_W-1:0] pc,
  output logic [3:0]        cs_n,
  output logic [3:0]        we_n,
  output logic [3:0]        oe_n,
  output logic              ack
);

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] pc_q, pc_d, lps_q, lps_d;
  logic [REP_W-1:0]  rep_q, rep_d;
  logic              lpo_q, lpo_d;
  logic [CNT_W-1:0]  lpl_q, lpl_d, lpc_q, lpc_d;
  logic              stall, word_done;
  logic              unused_bits;

  assign unused_bits = ^{word[23:18], word[15:13], word[11:10], word[6:3], word[1]};
  assign stall     = word[B_WAIT] & ~rdy;
  assign word_done = ~stall & (rep_q == word[B_REP_HI:B_REP_LO]);

  always_comb begin
    busy_d = busy_q;
    pc_d   = pc_q;
    rep_d  = rep_q;
    lpo_d  = lpo_q;
    lps_d  = lps_q;
    lpl_d  = lpl_q;
    lpc_d  = lpc_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        pc_d   = start_pc;
        rep_d  = '0;
        lpo_d  = 1'b0;
        lpc_d  = start_cnt;
      end
    end else if (!stall) begin
      if (!word_done) begin
        rep_d = rep_q + 1'b1;
      end else begin
        rep_d = '0;
        if (word[B_LAST]) begin
          busy_d = 1'b0;
        end else if (word[B_LOOP]) begin
          if (!lpo_q) begin
            lpo_d = 1'b1;
            lps_d = pc_q;
            lpl_d = (lpc_q == '0) ? '0 : lpc_q - 1'b1;
            pc_d  = pc_q + 1'b1;
          end else if (pc_q == lps_q) begin
            pc_d = pc_q + 1'b1;
          end else if (lpl_q != '0) begin
            lpl_d = lpl_q - 1'b1;
            pc_d  = lps_q;
          end else begin
            lpo_d = 1'b0;
            pc_d  = pc_q + 1'b1;
          end
        end else begin
          pc_d = pc_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pc_q   <= '0;
      rep_q  <= '0;
      lpo_q  <= 1'b0;
      lps_q  <= '0;
      lpl_q  <= '0;
      lpc_q  <= '0;
    end else if (busy_q | start) begin
      busy_q <= busy_d;
      pc_q   <= pc_d;
      rep_q  <= rep_d;
      lpo_q  <= lpo_d;
      lps_q  <= lps_d;
      lpl_q  <= lpl_d;
      lpc_q  <= lpc_d;
    end
  end

  assign busy = busy_q;
  assign pc   = pc_q;
  assign cs_n = busy_q ? word[B_CS_HI -: 4] : 4'hF;
  assign we_n = busy_q ? word[B_WE_HI -: 4] : 4'hF;
  assign oe_n = busy_q ? {word[B_OE_A], word[B_OE_A], word[B_OE_B], word[B_OE_B]} : 4'hF;
  assign ack  = busy_q & word[B_ACK] & ~stall;

endmodule

// File: rtl/wavefmt_seq.sv
module wavefmt_seq
  import wavefmt_pkg::*;
#(
  parameter int RAM_DEPTH   = 64,
  parameter int CNT_W       = 4,
  parameter int READ_ENTRY  = 0,
  parameter int WRITE_ENTRY = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        acc_req,
  input  logic        acc_write,
  input  logic        bus_rdy,
  output logic [3:0]  cs_n,
  output logic [3:0]  we_n,
  output logic [3:0]  oe_n,
  output logic        xfer_ack,
  output logic        busy
);

  localparam int ADDR_W = $clog2(RAM_DEPTH);

  seq_mode_e         mode_q;
  logic [ADDR_W-1:0] addr_q, pc;
  logic [CNT_W-1:0]  rd_cnt, wr_cnt, start_cnt;
  logic [WORD_W-1:0] mode_word, data_word, exec_word, host_word;
  logic [ADDR_W-1:0] start_pc;
  logic              idle_req, ram_wr, ram_rd, start;

  assign idle_req = acc_req & ~busy;
  assign ram_wr   = idle_req & (mode_q == MODE_WRAM);
  assign ram_rd   = idle_req & (mode_q == MODE_RRAM);
  assign start    = idle_req & ((mode_q == MODE_NORMAL) | (mode_q == MODE_RUN));

  always_comb begin
    if (mode_q == MODE_RUN) begin
      start_pc  = addr_q;
      start_cnt = rd_cnt;
    end else if (acc_write) begin
      start_pc  = ADDR_W'(WRITE_ENTRY);
      start_cnt = wr_cnt;
    end else begin
      start_pc  = ADDR_W'(READ_ENTRY);
      start_cnt = rd_cnt;
    end
  end

  wavefmt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .addr_inc(ram_wr | ram_rd), .data_load(ram_rd),
    .data_in(host_word), .mode(mode_q), .addr(addr_q), .rd_cnt(rd_cnt),
    .wr_cnt(wr_cnt), .mode_word(mode_word), .data_word(data_word)
  );

  wavefmt_ram #(.DEPTH(RAM_DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(ram_wr), .waddr(addr_q), .wdata(data_word),
    .raddr_exec(pc), .raddr_host(addr_q), .rdata_exec(exec_word), .rdata_host(host_word)
  );

  wavefmt_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
    .start_cnt(start_cnt), .word(exec_word), .rdy(bus_rdy), .busy(busy),
    .pc(pc), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .ack(xfer_ack)
  );

  assign host_rdata = host_sel ? data_word : mode_word;

endmodule

// File: rtl/wavefmt_seq_chk.sv
module wavefmt_seq_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              acc_req,
  input logic              host_wr,
  input logic              bus_rdy,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       exec_word,
  input logic [3:0]        cs_n,
  input logic [3:0]        we_n,
  input logic [3:0]        oe_n,
  input logic              xfer_ack
);

  assert_idle_negated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n == 4'hF && we_n == 4'hF && oe_n == 4'hF && !xfer_ack));

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && acc_req && (mode == 2'd0 || mode == 2'd3)) |=> busy);

  assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exec_word[12] && !bus_rdy) |=>
      (busy && $stable(cs_n) && $stable(we_n) && $stable(oe_n)));

  assert_ack_in_pattern_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> busy);

  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exec_word[0] && exec_word[9:8] == 2'b00 && !(exec_word[12] && !bus_rdy))
      |=> !busy);

  // R8 and R9: store access advances the address field
  assert_store_addr_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && acc_req && !host_wr && (mode == 2'd1 || mode == 2'd2))
      |=> addr == ADDR_W'($past(addr) + 1'b1));

  assert_store_no_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (mode == 2'd1 || mode == 2'd2)) |=> !busy);

endmodule

bind wavefmt_seq wavefmt_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .acc_req(acc_req), .host_wr(host_wr),
  .bus_rdy(bus_rdy), .mode(mode_q), .addr(addr_q), .exec_word(exec_word),
  .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .xfer_ack(xfer_ack)
);

// File: tb/tb_wavefmt_seq.sv
module tb_wavefmt_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_sel, acc_req, acc_write, bus_rdy;
  logic [31:0] host_wdata, host_rdata;
  logic [3:0]  cs_n, we_n, oe_n;
  logic        xfer_ack, busy;

  int checks = 0;
  int errors = 0;

  logic [13:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  wavefmt_seq dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .acc_req(acc_req),
    .acc_write(acc_write), .bus_rdy(bus_rdy), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .xfer_ack(xfer_ack), .busy(busy)
  );

  function automatic logic [31:0] mv(input logic [1:0] m, input logic [3:0] rc,
                                     input logic [3:0] wc, input logic [5:0] a);
    return {2'b00, m, 4'h0, rc, wc, 10'h0, a};
  endfunction

  function automatic logic [13:0] mk(input logic b, input logic [3:0] c,
                                     input logic [3:0] w, input logic [3:0] o,
                                     input logic t);
    return {b, c, w, o, t};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per clock and compares the outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [13:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {18'h0, busy, cs_n, we_n, oe_n, xfer_ack}, {18'h0, e});
    end
  end

  task automatic push(input string tag, input logic [13:0] item, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(item);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic host_write(input logic sel, input logic [31:0] val);
    @(posedge clk); #1;
    host_wr = 1'b1; host_sel = sel; host_wdata = val;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic access(input logic wr);
    @(posedge clk); #1;
    acc_req = 1'b1; acc_write = wr;
    @(posedge clk); #1;
    acc_req = 1'b0;
  endtask

  task automatic read_reg(input logic sel, input string tag, input logic [31:0] exp);
    host_sel = sel; #1;
    chk(tag, host_rdata, exp);
  endtask

  // expected items for the write pattern body: w24 then w25 (two clocks)
  task automatic push_body(input string tag, input int passes);
    for (int p = 0; p < passes; p++) begin
      push(tag, mk(1'b1, 4'h0, 4'b0011, 4'hF, 1'b0), 1);
      push(tag, mk(1'b1, 4'h0, 4'h0, 4'hF, 1'b0), 2);
    end
    push(tag, mk(1'b1, 4'h0, 4'hF, 4'hF, 1'b1), 1);
    push(tag, mk(1'b0, 4'hF, 4'hF, 4'hF, 1'b0), 2);
  endtask

  task automatic push_read(input string tag, input int wait_clks);
    push(tag, mk(1'b1, 4'h0, 4'hF, 4'hF, 1'b0), 3);
    push(tag, mk(1'b1, 4'b0001, 4'hF, 4'b0011, 1'b0), 1);
    push(tag, mk(1'b1, 4'h0, 4'hF, 4'h0, 1'b0), 1 + wait_clks);
    push(tag, mk(1'b1, 4'h0, 4'hF, 4'h0, 1'b1), 1);
    push(tag, mk(1'b1, 4'hF, 4'hF, 4'hF, 1'b0), 1);
    push(tag, mk(1'b0, 4'hF, 4'hF, 4'hF, 1'b0), 2);
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd_words [5];
    logic [31:0] wr_words [3];
    rd_words = '{32'h0FF3_0200, 32'h1FF1_0000, 32'h0FF0_1000, 32'h0FF0_0004, 32'hFFF3_0001};
    wr_words = '{32'h03F3_0080, 32'h00F3_0180, 32'h0FF3_0005};

    rst_n = 1'b0; host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
    acc_req = 1'b0; acc_write = 1'b0; bus_rdy = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 cs_n", {28'h0, cs_n}, 32'hF);
    chk("R1 we_n", {28'h0, we_n}, 32'hF);
    chk("R1 oe_n", {28'h0, oe_n}, 32'hF);
    chk("R1 ack/busy", {30'h0, xfer_ack, busy}, 32'h0);
    read_reg(1'b0, "R1 mode reg", 32'h0);

    // R13 unwritten word holds the idle word
    host_write(1'b0, mv(2'd2, 4'd0, 4'd0, 6'd40));
    access(1'b0);
    read_reg(1'b1, "R13 idle fill", 32'hFFF3_0001);

    // R8 fill the read pattern at word 0
    host_write(1'b0, mv(2'd1, 4'd0, 4'd0, 6'd0));
    for (int i = 0; i < 5; i++) begin
      host_write(1'b1, rd_words[i]);
      access(1'b0);
      chk("R12 store mode no start", {31'h0, busy}, 32'h0);
    end
    read_reg(1'b0, "R8 addr after fill", mv(2'd1, 4'd0, 4'd0, 6'd5));

    // R8 fill the write pattern at word 24
    host_write(1'b0, mv(2'd1, 4'd0, 4'd0, 6'd24));
    for (int i = 0; i < 3; i++) begin
      host_write(1'b1, wr_words[i]);
      access(1'b1);
    end
    read_reg(1'b0, "R8 addr after second fill", mv(2'd1, 4'd0, 4'd0, 6'd27));

    // R9 read back one stored word
    host_write(1'b0, mv(2'd2, 4'd0, 4'd0, 6'd25));
    access(1'b0);
    read_reg(1'b1, "R9 data loaded", wr_words[1]);
    read_reg(1'b0, "R9 addr advanced", mv(2'd2, 4'd0, 4'd0, 6'd26));

    // R2 R3 R4 R6 R7 read pattern, plus a request while busy (R12)
    host_write(1'b0, mv(2'd0, 4'd0, 4'd3, 6'd0));
    access(1'b0);
    push_read("R2/R3/R4/R6/R7/R12 read pattern", 0);
    @(posedge clk); #1;
    acc_req = 1'b1; acc_write = 1'b1;
    @(posedge clk); #1;
    acc_req = 1'b0;
    drain();

    // R5 stall on ready low for three clocks
    bus_rdy = 1'b0;
    access(1'b0);
    push_read("R5 wait stall", 3);
    repeat (7) @(posedge clk);
    #1 bus_rdy = 1'b1;
    drain();

    // R10 loop body three times
    access(1'b1);
    push_body("R10 loop count 3", 3);
    drain();

    // R10 loop count zero runs once
    host_write(1'b0, mv(2'd0, 4'd0, 4'd0, 6'd0));
    access(1'b1);
    push_body("R10 loop count 0", 1);
    drain();

    // R11 run mode from address 24 with read loop count 2
    host_write(1'b0, mv(2'd3, 4'd2, 4'd5, 6'd24));
    access(1'b1);
    push_body("R11 run mode", 2);
    drain();

    // R11 R13 run an untouched word: one busy clock, strobes negated
    host_write(1'b0, mv(2'd3, 4'd0, 4'd0, 6'd40));
    access(1'b0);
    push("R11/R13 run idle word", mk(1'b1, 4'hF, 4'hF, 4'hF, 1'b0), 1);
    push("R11/R13 run idle word", mk(1'b0, 4'hF, 4'hF, 4'hF, 1'b0), 2);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule